// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block sits between a host processor and an embedded controller. The host sees a small register window on a valid/address/data bus. It places up to sixteen bytes of arguments in an outbound buffer, using byte lanes if it wants to, and then writes a command word. That single write starts the exchange. The block marks itself busy and raises a one-cycle notification toward the controller. The controller can read the latched command word and the outbound buffer at any time.

The controller answers in two steps. It first fills an inbound buffer, word by word. It then asserts a completion strobe that carries a fail flag, an error code and an initiator tag. Completion clears busy and records the outcome in the status word. If the command asked for an interrupt, completion also pulses the host interrupt line and sets a flag that the host clears by writing a one to it. A host that did not ask for an interrupt polls the busy bit instead.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word reads 0, and host_irq and ctl_cmd_irq are low.
- R2: A host write to offset 0x00 while not busy is accepted. On the following cycle status bit 0 (busy) is 1, status bits [7:4] hold bits [15:12] of the written word, status bit 1 and bits [23:16] are 0, ctl_cmd_word equals the written word, and ctl_cmd_irq is high for exactly that one cycle.
- R3: A host write to offset 0x00 while busy is ignored. ctl_cmd_word keeps its value, ctl_cmd_irq stays low, and status bit 3 (overrun) becomes 1 and stays 1 until reset.
- R4: ctl_done while busy clears status bit 0 and loads status bit 1 from ctl_err, bits [23:16] from ctl_err_code and bits [15:8] from ctl_init_id. ctl_done while not busy changes nothing.
- R5: When the accepted command had bit 8 set, completion sets status bit 2 and drives host_irq high for exactly one cycle. When bit 8 was clear, neither happens.
- R6: A host write to offset 0x04 with bit 2 set clears status bit 2. All other bits written to offset 0x04 have no effect.
- R7: If a status write that clears bit 2 falls in the same cycle as a completion that sets it, status bit 2 ends up set.
- R8: Host writes to 0x80 + 4*i update word i of the outbound buffer in the byte lanes selected by hst_be. The controller reads word i as ctl_wbuf_data when ctl_wbuf_idx = i. Host reads in that range return 0.
- R9: ctl_rbuf_we writes ctl_rbuf_data into word ctl_rbuf_idx of the inbound buffer. The host reads it at 0x90 + 4*i, and host writes there have no effect.
- R10: Host reads return data on hst_rdata one cycle after the read request. A read of offset 0x00 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access strobe |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_be | input | 4 | Host write byte lanes |
| hst_rdata | output | 32 | Host read data, one cycle after request |
| host_irq | output | 1 | Completion interrupt pulse to host |
| ctl_cmd_irq | output | 1 | New-command pulse to controller |
| ctl_cmd_word | output | 32 | Last accepted command word |
| ctl_wbuf_idx | input | 2 | Outbound buffer word select |
| ctl_wbuf_data | output | 32 | Selected outbound buffer word |
| ctl_rbuf_we | input | 1 | Inbound buffer write strobe |
| ctl_rbuf_idx | input | 2 | Inbound buffer word select |
| ctl_rbuf_data | input | 32 | Inbound buffer write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Completion fail flag |
| ctl_err_code | input | 8 | Completion error code |
| ctl_init_id | input | 8 | Completion initiator tag |

## Verification
Two actions can land on the interrupt flag in the same cycle: the host's write-one-to-clear and a completion that sets the flag. The bench sets this up on purpose. It leaves the flag set from one interrupting command, starts a second interrupting command, and then drives the clearing status write and ctl_done on the same edge. It judges the result by reading back status bit 2, which must still be 1. A second collision drives a command write on the same edge as the completion. That write must count as an overrun because busy is still set at that edge.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

   localparam logic [7:0] OFS_CMD  = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;

   localparam int ST_BUSY = 0;
   localparam int ST_FAIL = 1;
   localparam int ST_FLAG = 2;
   localparam int ST_OVR  = 3;

   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] len;
      logic [3:0] sub;
      logic [2:0] rsv_lo;
      logic       notify;
      logic [7:0] opcode;
   } cmd_word_t;

   typedef struct packed {
      logic [7:0] rsv;
      logic [7:0] code;
      logic [7:0] origin;
      logic [3:0] sub;
      logic       ovr;
      logic       flag;
      logic       fail;
      logic       busy;
   } stat_word_t;

endpackage

// File: rtl/ipc_mbx_buf.sv
module ipc_mbx_buf #(
   parameter int WORDS   = 4,
   parameter int DW      = 32,
   parameter bit BYTE_EN = 1'b1,
   localparam int IW     = $clog2(WORDS),
   localparam int LANES  = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic [LANES-1:0] wr_be,
   input  logic [IW-1:0]    rd_idx,
   output logic [DW-1:0]    rd_data
);

   logic [DW-1:0] mem [WORDS];

   generate
      if (DW % 8 != 0) begin : g_bad_width
         $error("buffer width must be whole bytes");
      end
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         if (BYTE_EN) begin : g_lanes
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  mem[w] <= '0;
               end else if (wr_en && wr_idx == IW'(w)) begin
                  for (int b = 0; b < LANES; b++) begin
                     if (wr_be[b]) mem[w][b*8 +: 8] <= wr_data[b*8 +: 8];
                  end
               end
            end
         end else begin : g_full
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  mem[w] <= '0;
               end else if (wr_en && wr_idx == IW'(w)) begin
                  mem[w] <= wr_data;
               end
            end
         end
      end
   endgenerate

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl
   import ipc_mbx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_data,
   input  logic        stat_wr,
   input  logic [31:0] stat_data,
   input  logic        done,
   input  logic        fail,
   input  logic [7:0]  code,
   input  logic [7:0]  origin,
   output logic [31:0] status,
   output logic [31:0] cmd_word,
   output logic        cmd_irq,
   output logic        host_irq
);

   stat_word_t st_q;
   cmd_word_t  cmd_q;
   cmd_word_t  cmd_in;
   logic       accept, reject, finish, raise, clear;

   assign cmd_in = cmd_word_t'(cmd_data);
   assign accept = cmd_wr && !st_q.busy;
   assign reject = cmd_wr &&  st_q.busy;
   assign finish = done   &&  st_q.busy;
   assign raise  = finish &&  cmd_q.notify;
   assign clear  = stat_wr && stat_data[ST_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= '0;
         cmd_q    <= '0;
         cmd_irq  <= 1'b0;
         host_irq <= 1'b0;
      end else begin
         cmd_irq  <= accept;
         host_irq <= raise;
         if (accept) begin
            cmd_q     <= cmd_in;
            st_q.busy <= 1'b1;
            st_q.fail <= 1'b0;
            st_q.code <= '0;
            st_q.sub  <= cmd_in.sub;
         end
         if (reject) st_q.ovr <= 1'b1;
         if (finish) begin
            st_q.busy   <= 1'b0;
            st_q.fail   <= fail;
            st_q.code   <= code;
            st_q.origin <= origin;
         end
         if (raise)      st_q.flag <= 1'b1;
         else if (clear) st_q.flag <= 1'b0;
      end
   end

   assign status   = 32'(st_q);
   assign cmd_word = 32'(cmd_q);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbx_pkg::*;
#(
   parameter int         BUF_WORDS = 4,
   parameter logic [7:0] WBUF_BASE = 8'h80,
   parameter logic [7:0] RBUF_BASE = 8'h90,
   localparam int        IW        = $clog2(BUF_WORDS),
   localparam int        SPAN      = BUF_WORDS * 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_valid,
   input  logic          hst_write,
   input  logic [7:0]    hst_addr,
   input  logic [31:0]   hst_wdata,
   input  logic [3:0]    hst_be,
   output logic [31:0]   hst_rdata,
   output logic          host_irq,
   output logic          ctl_cmd_irq,
   output logic [31:0]   ctl_cmd_word,
   input  logic [IW-1:0] ctl_wbuf_idx,
   output logic [31:0]   ctl_wbuf_data,
   input  logic          ctl_rbuf_we,
   input  logic [IW-1:0] ctl_rbuf_idx,
   input  logic [31:0]   ctl_rbuf_data,
   input  logic          ctl_done,
   input  logic          ctl_err,
   input  logic [7:0]    ctl_err_code,
   input  logic [7:0]    ctl_init_id
);

   generate
      if (BUF_WORDS < 2 || SPAN > 16) begin : g_bad_depth
         $error("BUF_WORDS must lie between 2 and 4");
      end
      if (WBUF_BASE[3:0] != 4'h0 || RBUF_BASE[3:0] != 4'h0) begin : g_bad_base
         $error("buffer bases must be 16-byte aligned");
      end
      if (WBUF_BASE == RBUF_BASE) begin : g_overlap
         $error("buffer windows must differ");
      end
   endgenerate

   logic [7:0]    w_off, r_off;
   logic          in_wbuf, in_rbuf, hw, hr;
   logic [IW-1:0] host_idx_w, host_idx_r;
   logic [31:0]   stat_word, rbuf_word;

   assign hw = hst_valid &&  hst_write;
   assign hr = hst_valid && !hst_write;

   assign w_off   = hst_addr - WBUF_BASE;
   assign r_off   = hst_addr - RBUF_BASE;
   assign in_wbuf = (hst_addr >= WBUF_BASE) && (32'(w_off) < SPAN);
   assign in_rbuf = (hst_addr >= RBUF_BASE) && (32'(r_off) < SPAN);
   assign host_idx_w = w_off[IW+1:2];
   assign host_idx_r = r_off[IW+1:2];

   ipc_mbx_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (hw && hst_addr == OFS_CMD),
      .cmd_data  (hst_wdata),
      .stat_wr   (hw && hst_addr == OFS_STAT),
      .stat_data (hst_wdata),
      .done      (ctl_done),
      .fail      (ctl_err),
      .code      (ctl_err_code),
      .origin    (ctl_init_id),
      .status    (stat_word),
      .cmd_word  (ctl_cmd_word),
      .cmd_irq   (ctl_cmd_irq),
      .host_irq  (host_irq)
   );

   ipc_mbx_buf #(.WORDS(BUF_WORDS), .DW(32), .BYTE_EN(1'b1)) u_wbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hw && in_wbuf),
      .wr_idx  (host_idx_w),
      .wr_data (hst_wdata),
      .wr_be   (hst_be),
      .rd_idx  (ctl_wbuf_idx),
      .rd_data (ctl_wbuf_data)
   );

   ipc_mbx_buf #(.WORDS(BUF_WORDS), .DW(32), .BYTE_EN(1'b0)) u_rbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_rbuf_we),
      .wr_idx  (ctl_rbuf_idx),
      .wr_data (ctl_rbuf_data),
      .wr_be   (4'hF),
      .rd_idx  (host_idx_r),
      .rd_data (rbuf_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hst_rdata <= '0;
      end else if (hr) begin
         if (in_rbuf)                    hst_rdata <= rbuf_word;
         else if (hst_addr == OFS_STAT)  hst_rdata <= stat_word;
         else                            hst_rdata <= '0;
      end
   end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hst_valid,
   input logic        hst_write,
   input logic [7:0]  hst_addr,
   input logic [31:0] hst_wdata,
   input logic [31:0] status,
   input logic [31:0] ctl_cmd_word,
   input logic        ctl_cmd_irq,
   input logic        host_irq,
   input logic        ctl_done
);

   logic cmd_wr, stat_wr;
   assign cmd_wr  = hst_valid && hst_write && hst_addr == 8'h00;
   assign stat_wr = hst_valid && hst_write && hst_addr == 8'h04;

   p_cmdirq_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_cmd_irq |-> status[0]);

   p_cmdirq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_cmd_irq |=> !ctl_cmd_irq);

   p_busy_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && status[0]) |=> ($stable(ctl_cmd_word) && status[3] && !ctl_cmd_irq));

   p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] |=> status[3]);

   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_done && status[0]) |=> !status[0]);

   p_hirq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> status[2]);

   p_hirq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |=> !host_irq);

   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && hst_wdata[2] && !ctl_done) |=> !status[2]);

endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_valid    (hst_valid),
   .hst_write    (hst_write),
   .hst_addr     (hst_addr),
   .hst_wdata    (hst_wdata),
   .status       (stat_word),
   .ctl_cmd_word (ctl_cmd_word),
   .ctl_cmd_irq  (ctl_cmd_irq),
   .host_irq     (host_irq),
   .ctl_done     (ctl_done)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_valid = 1'b0, hst_write = 1'b0;
   logic [7:0]  hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [3:0]  hst_be = '0;
   logic [31:0] hst_rdata;
   logic        host_irq, ctl_cmd_irq;
   logic [31:0] ctl_cmd_word, ctl_wbuf_data;
   logic [1:0]  ctl_wbuf_idx = '0, ctl_rbuf_idx = '0;
   logic        ctl_rbuf_we = 1'b0;
   logic [31:0] ctl_rbuf_data = '0;
   logic        ctl_done = 1'b0, ctl_err = 1'b0;
   logic [7:0]  ctl_err_code = '0, ctl_init_id = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_mailbox u_dut (.*);

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference state
   bit          m_busy, m_fail, m_flag, m_ovr, m_notify;
   logic [3:0]  m_sub;
   logic [7:0]  m_code, m_org;
   logic [31:0] m_cmd;

   function automatic logic [31:0] exp_status();
      return {8'h00, m_code, m_org, m_sub, m_ovr, m_flag, m_fail, m_busy};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      hst_valid = 1; hst_write = 1; hst_addr = a; hst_wdata = d; hst_be = be;
      @(negedge clk);
      hst_valid = 0; hst_write = 0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_valid = 1; hst_write = 0; hst_addr = a;
      @(negedge clk);
      hst_valid = 0;
      d = hst_rdata;
   endtask

   task automatic model_cmd(input logic [31:0] w);
      if (m_busy) m_ovr = 1;
      else begin
         m_busy = 1; m_fail = 0; m_code = 0;
         m_sub = w[15:12]; m_notify = w[8]; m_cmd = w;
      end
   endtask

   task automatic issue_cmd(input logic [31:0] w);
      bit acc;
      acc = !m_busy;
      bus_wr(8'h00, w, 4'hF);
      model_cmd(w);
      check(acc ? "R2 cmd_irq" : "R3 cmd_irq", {31'b0, ctl_cmd_irq}, {31'b0, acc});
      check(acc ? "R2 cmd_word" : "R3 cmd_word", ctl_cmd_word, m_cmd);
   endtask

   function automatic bit model_done(input bit e, input logic [7:0] c, input logic [7:0] o);
      if (!m_busy) return 0;
      m_busy = 0; m_fail = e; m_code = c; m_org = o;
      if (m_notify) m_flag = 1;
      return m_notify;
   endfunction

   task automatic complete(input bit e, input logic [7:0] c, input logic [7:0] o);
      bit irq;
      @(negedge clk);
      ctl_done = 1; ctl_err = e; ctl_err_code = c; ctl_init_id = o;
      @(negedge clk);
      ctl_done = 0;
      irq = model_done(e, c, o);
      check("R5 host_irq", {31'b0, host_irq}, {31'b0, irq});
   endtask

   task automatic check_status(input string req);
      logic [31:0] d;
      bus_rd(8'h04, d);
      check(req, d, exp_status());
   endtask

   initial begin
      logic [31:0] d;
      bit irq;
      void'($urandom(32'd20240517));
      {m_busy, m_fail, m_flag, m_ovr, m_notify} = '0;
      m_sub = 0; m_code = 0; m_org = 0; m_cmd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 status", u_dut.hst_rdata, 32'h0);
      check("R1 irqs", {30'b0, host_irq, ctl_cmd_irq}, 32'h0);
      check_status("R1 status read");

      // R8 outbound buffer with byte lanes
      bus_wr(8'h84, 32'h11223344, 4'hF);
      bus_wr(8'h84, 32'hAABBCCDD, 4'b0101);
      ctl_wbuf_idx = 2'd1; #1;
      check("R8 lane merge", ctl_wbuf_data, 32'h11BB33DD);
      bus_rd(8'h84, d);
      check("R8 host read zero", d, 32'h0);

      // R2 accepted command, polled
      issue_cmd(32'h0003_5042);
      @(negedge clk);
      check("R2 cmd_irq one cycle", {31'b0, ctl_cmd_irq}, 32'h0);
      check_status("R2 status busy");
      bus_rd(8'h00, d);
      check("R10 cmd reads zero", d, 32'h0);

      // R3 command while busy
      issue_cmd(32'h0000_7199);
      check_status("R3 overrun");

      // R9 inbound buffer
      @(negedge clk);
      ctl_rbuf_we = 1; ctl_rbuf_idx = 2'd2; ctl_rbuf_data = 32'hCAFE_F00D;
      @(negedge clk);
      ctl_rbuf_we = 0;
      bus_wr(8'h98, 32'h1234_5678, 4'hF);
      bus_rd(8'h98, d);
      check("R9 rbuf read", d, 32'hCAFE_F00D);

      // R4 completion with fail, no notify
      complete(1'b1, 8'h5A, 8'h21);
      check_status("R4 completion");
      complete(1'b0, 8'h77, 8'h66);
      check_status("R4 idle done ignored");

      // R5 notify, R6 W1C and ignored bits
      issue_cmd(32'h0000_9100);
      complete(1'b0, 8'h00, 8'h03);
      check_status("R5 flag set");
      bus_wr(8'h04, 32'hFFFF_FFFB, 4'hF);
      check_status("R6 other bits no effect");
      bus_wr(8'h04, 32'h0000_0004, 4'hF);
      m_flag = 0;
      check_status("R6 w1c");

      // R7 collision: W1C and completion in the same cycle
      issue_cmd(32'h0000_2100);
      complete(1'b0, 8'h00, 8'h04);
      issue_cmd(32'h0000_3100);
      @(negedge clk);
      hst_valid = 1; hst_write = 1; hst_addr = 8'h04; hst_wdata = 32'h4; hst_be = 4'hF;
      ctl_done = 1; ctl_err = 0; ctl_err_code = 8'h0C; ctl_init_id = 8'h05;
      @(negedge clk);
      hst_valid = 0; hst_write = 0; ctl_done = 0;
      m_flag = 0;
      irq = model_done(1'b0, 8'h0C, 8'h05);
      check("R7 host_irq", {31'b0, host_irq}, {31'b0, irq});
      check_status("R7 set wins");

      // R3 collision: command write on the completion edge
      issue_cmd(32'h0000_4000);
      @(negedge clk);
      hst_valid = 1; hst_write = 1; hst_addr = 8'h00; hst_wdata = 32'h0000_5000;
      ctl_done = 1; ctl_err = 0;
      @(negedge clk);
      hst_valid = 0; hst_write = 0; ctl_done = 0;
      model_cmd(32'h0000_5000);
      void'(model_done(1'b0, 8'h0C, 8'h05));
      check("R3 collision word", ctl_cmd_word, 32'h0000_4000);
      check_status("R3 collision status");

      // random mix
      for (int i = 0; i < 60; i++) begin
         int op;
         op = $urandom % 4;
         case (op)
            0: issue_cmd($urandom);
            1: complete(1'($urandom), 8'($urandom), 8'($urandom));
            2: begin
               d = $urandom;
               bus_wr(8'h04, d, 4'hF);
               if (d[2]) m_flag = 0;
            end
            default: @(negedge clk);
         endcase
         check_status("R4 random status");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule